// File: doc/BRIEF.md
# Cascadable Synchronous Binary Up-Counter Slice

This block is a synchronous binary up-counter of parameterised width (eight bits by default). It is meant to be one slice of a wider counter. A low-true count enable makes it advance by one on each rising clock edge. When that enable is high, the counter holds its value.

A low-true load strobe copies a preset bus into the counter on the next edge. A reload-at-terminal-count control lets the slice act as a programmable divider. With this control set, the counter returns to the preset value at the all-ones state instead of wrapping to zero. The divide ratio is then 2^WIDTH minus the preset value.

A low-true terminal-count output is a decode of the present state. It goes low while every counter bit is 1. Wiring it straight into the enable of the next more significant slice builds a wider counter with no extra gates. The upper slice then advances only on the edge that follows the lower slice's all-ones state.

Top module: `cnt_slice`

## Requirements
- R1: `tcN` is 0 exactly when every bit of `count` is 1, and 1 otherwise. It is combinational and valid in the same cycle as the state it decodes.
- R2: With `rst` = 0, `loadN` = 1 and `cntEnN` = 1, `count` keeps its value across the edge, whatever `reloadAtTc` and `preset` are.
- R3: With `rst` = 0, `loadN` = 1, `cntEnN` = 0 and `count` not all ones, `count` becomes `count` + 1 on the edge.
- R4: With `rst` = 0, `loadN` = 1, `cntEnN` = 0, `reloadAtTc` = 1 and `count` all ones, `count` takes `preset` on the edge. With preset value P held, `tcN` then goes low once every 2^WIDTH − P edges (113 for P = 8'h8F).
- R5: With `rst` = 0, `loadN` = 1, `cntEnN` = 0, `reloadAtTc` = 0 and `count` all ones, `count` wraps to zero on the edge.
- R6: With `rst` = 0 and `loadN` = 0, `count` takes `preset` on the edge (bit 0 least significant), whatever `cntEnN` and `reloadAtTc` are.
- R7: `rst` = 1 is synchronous and clears `count` to zero on the edge. It overrides every other input.
- R8: When the `tcN` of one slice drives the `cntEnN` of a second slice on the same clock, the pair counts as one binary counter of twice the width. The upper slice steps on the edge right after the lower slice shows all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the count |
| cntEnN | input | 1 | Count enable, active low; high holds the count |
| loadN | input | 1 | Parallel load strobe, active low, highest priority after reset |
| reloadAtTc | input | 1 | When high, the all-ones state reloads the preset instead of wrapping |
| preset | input | WIDTH | Parallel preset value, bit 0 least significant |
| count | output | WIDTH | Current counter value |
| tcN | output | 1 | Terminal count, active low, low while count is all ones |

## Verification
Every state bit is visible on `count`. A wrong next-state choice therefore shows at the ports one edge after the cycle that caused it. Examples are a missed hold, a reload taken when the count is disabled, or load losing priority to counting. A stuck or wrong decode of the all-ones state shows at once on `tcN`. Over a full divider period it also changes the spacing between terminal-count pulses. In a chained pair, that wrong decode makes the upper slice step one edge early or late.

// File: rtl/cnt_slice_pkg.sv
package cnt_slice_pkg;
  // Strobes passed from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic clr;
    logic load;
    logic inc;
  } ctrlStrobes_t;
endpackage

// File: rtl/cnt_slice_ctrl.sv
module cnt_slice_ctrl
  import cnt_slice_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cntEnN,
  input  logic         loadN,
  input  logic         reloadAtTc,
  input  logic         atMax,
  output ctrlStrobes_t strb
);
  // Priority: reset, explicit load, hold, reload at all ones, increment.
  always_comb begin
    strb = '0;
    if (rst) begin
      strb.clr = 1'b1;
    end else if (!loadN) begin
      strb.load = 1'b1;
    end else if (!cntEnN) begin
      if (atMax && reloadAtTc) strb.load = 1'b1;
      else                     strb.inc  = 1'b1;
    end
  end

  // R6 / R7: the strobes never conflict.
  a_r6_one_strobe: assert property (@(posedge clk)
    $onehot0({strb.clr, strb.load, strb.inc}));

  // R6: an explicit load wins over counting and over reload.
  a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
    !loadN |-> (strb.load && !strb.inc));
endmodule

// File: rtl/cnt_slice_dp.sv
module cnt_slice_dp
  import cnt_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  ctrlStrobes_t     strb,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] countQ,
  output logic             atMax
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (strb.clr)       countQ <= '0;
    else if (strb.load) countQ <= preset;
    else if (strb.inc)  countQ <= countQ + ONE;
  end

  assign atMax = &countQ;

  // R2: with no strobe set, the register does not move.
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (strb.clr)
    !(strb.load || strb.inc) |=> $stable(countQ));
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_slice_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cntEnN,
  input  logic             loadN,
  input  logic             reloadAtTc,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             tcN
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  ctrlStrobes_t strb;
  logic         atMax;

  cnt_slice_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cntEnN     (cntEnN),
    .loadN      (loadN),
    .reloadAtTc (reloadAtTc),
    .atMax      (atMax),
    .strb       (strb)
  );

  cnt_slice_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .strb   (strb),
    .preset (preset),
    .countQ (count),
    .atMax  (atMax)
  );

  assign tcN = ~atMax;

  // R7: reset clears the count on the next edge.
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (count == '0));

  // R2: hold keeps the value.
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (loadN && cntEnN) |=> $stable(count));

  // R3: count up below all ones.
  a_r3_increment: assert property (@(posedge clk) disable iff (rst)
    (loadN && !cntEnN && tcN) |=> (count == $past(count) + ONE));

  // R4: reload at all ones.
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (loadN && !cntEnN && !tcN && reloadAtTc) |=> (count == $past(preset)));

  // R5: wrap to zero at all ones.
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (loadN && !cntEnN && !tcN && !reloadAtTc) |=> (count == '0));

  // R6: parallel load.
  a_r6_load: assert property (@(posedge clk) disable iff (rst)
    !loadN |=> (count == $past(preset)));
endmodule

// File: tb/sim_cnt_slice.sv
module sim_cnt_slice;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 15;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst, cntEnN, loadN, reloadAtTc;
  logic [W-1:0] preset;
  logic [W-1:0] count, upCount;
  logic         tcN, upTcN;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnt_slice #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .cntEnN(cntEnN), .loadN(loadN),
    .reloadAtTc(reloadAtTc), .preset(preset), .count(count), .tcN(tcN)
  );

  // Upper slice for the chaining test: its enable is the lower slice's tcN.
  cnt_slice #(.WIDTH(W)) u1 (
    .clk(clk), .rst(rst), .cntEnN(tcN), .loadN(loadN),
    .reloadAtTc(1'b0), .preset(preset), .count(upCount), .tcN(upTcN)
  );

  // Vector fields: {rst, loadN, cntEnN, reloadAtTc, preset[8], expCount[8], expTcN}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,1'b1},  // 0  R7 reset
    {1'b0,1'b0,1'b1,1'b0,8'hFD,8'hFD,1'b1},  // 1  R6 load
    {1'b0,1'b1,1'b0,1'b0,8'h00,8'hFE,1'b1},  // 2  R3 inc
    {1'b0,1'b1,1'b0,1'b0,8'h00,8'hFF,1'b0},  // 3  R1 tc low
    {1'b0,1'b1,1'b1,1'b0,8'h00,8'hFF,1'b0},  // 4  R2 hold
    {1'b0,1'b1,1'b0,1'b0,8'h33,8'h00,1'b1},  // 5  R5 wrap
    {1'b0,1'b0,1'b0,1'b1,8'hFF,8'hFF,1'b0},  // 6  R6 load beats count
    {1'b0,1'b1,1'b0,1'b1,8'h8F,8'h8F,1'b1},  // 7  R4 reload
    {1'b0,1'b0,1'b0,1'b1,8'h10,8'h10,1'b1},  // 8  R6 load beats count
    {1'b0,1'b1,1'b0,1'b1,8'h77,8'h11,1'b1},  // 9  R3 inc
    {1'b0,1'b1,1'b1,1'b1,8'h77,8'h11,1'b1},  // 10 R2 hold
    {1'b1,1'b0,1'b0,1'b1,8'h55,8'h00,1'b1},  // 11 R7 reset beats load
    {1'b0,1'b0,1'b1,1'b0,8'hFF,8'hFF,1'b0},  // 12 R6 load all ones
    {1'b0,1'b1,1'b1,1'b1,8'h22,8'hFF,1'b0},  // 13 R2 no reload when held
    {1'b0,1'b0,1'b1,1'b0,8'h01,8'h01,1'b1}   // 14 R6 load, R1 tc high
  };

  function automatic string tagOf(int i);
    case (i)
      0, 11:             return "R7";
      1, 6, 8, 12, 14:   return "R6";
      2, 9:              return "R3";
      3:                 return "R1";
      4, 10, 13:         return "R2";
      5:                 return "R5";
      default:           return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic r, logic ld, logic ce, logic rl, logic [W-1:0] p);
    @(negedge clk);
    rst = r; loadN = ld; cntEnN = ce; reloadAtTc = rl; preset = p;
  endtask

  task automatic stepSample();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    rst = 1'b1; loadN = 1'b1; cntEnN = 1'b1; reloadAtTc = 1'b0; preset = '0;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
      stepSample();
      check(tagOf(i), 32'(count), 32'(VEC[i][8:1]));
      check("R1", 32'(tcN), 32'(VEC[i][0]));
    end

    // R4: divide-by-113 with preset 8'h8F, measured between tcN pulses
    begin
      int gap;
      drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h8F);
      stepSample();
      drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h8F);
      gap = 0;
      do begin stepSample(); gap++; end while (tcN !== 1'b0 && gap < 400);
      check("R4 edges from 8F to first tc", 32'(gap), 32'd112);
      gap = 0;
      do begin stepSample(); gap++; end while (tcN !== 1'b0 && gap < 400);
      check("R4 divider period", 32'(gap), 32'd113);
      stepSample();
      check("R4 reload value", 32'(count), 32'h8F);
    end

    // R8: chained pair counting as one 16-bit counter
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    stepSample();
    check("R8 upper reset", 32'(upCount), 32'd0);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    for (int k = 0; k < 255; k++) stepSample();
    check("R8 lower at all ones", 32'(count), 32'hFF);
    check("R8 upper not yet stepped", 32'(upCount), 32'd0);
    stepSample();
    check("R8 upper steps after lower tc", 32'(upCount), 32'd1);
    check("R8 lower wrapped", 32'(count), 32'd0);
    for (int k = 0; k < 300; k++) stepSample();
    check("R8 combined value", {16'd0, upCount, count}, 32'd556);

    // R7: reset from a nonzero count
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    stepSample();
    check("R7 reset clears", 32'(count), 32'd0);
    check("R7 reset clears upper", 32'(upCount), 32'd0);

    done = 1;
    finishRun();
  end
endmodule